// File: doc/BRIEF.md
# Reed-Solomon Symbol Correction Applier

This block sits after a Reed-Solomon decoder whose code symbols are 12 bits wide. The decoder reports up to four error locations, given as symbol positions, and a 12-bit error pattern for each. The block turns each location into byte addresses and nibble masks in a byte-wide page memory. It then repairs the page in place, one byte at a time. For each byte it reads the byte, XORs the mask into it and writes the result back, all over a single RAM port.

The page memory holds the data bytes followed directly by the spare bytes, so spare byte k sits at byte address DATA_BYTES + k. Symbol 0 is a short symbol that holds only 8 data bits. Each later symbol p starts at bit 12p - 4 of the byte stream. Odd positions start on a byte boundary and even positions start mid-byte. A symbol whose first byte is the last data byte also covers the first spare byte. Entries are applied in the order given. If an entry cannot be applied, the block stops at that entry, raises fail and reports no correction count. Any bytes already repaired keep their new values.

Top module: `rs_symbol_fixer`

## Requirements
- R1: After reset, done, fail and corrCount are 0 and no RAM access is made (ramEn low) until a start is accepted.
- R2: For an odd position p that is not above MAX_POS, byte floor(3p/2) is XORed with pattern[11:4], and the next byte is XORed with {pattern[3:0], 4'b0000}.
- R3: For an even nonzero position p that is not above MAX_POS, byte 3p/2 - 1 is XORed with {4'b0000, pattern[11:8]}, and byte 3p/2 is XORed with pattern[7:0].
- R4: Position 0 touches only byte 0. If pattern[11:8] is zero, byte 0 is XORed with pattern[7:0]. Otherwise the request fails at that entry and no byte is written for it.
- R5: Byte addresses are linear across the boundary, with spare byte k at address DATA_BYTES + k. A symbol whose first byte is the last data byte therefore updates that byte and spare byte 0, and every access stays below DATA_BYTES + SPARE_BYTES.
- R6: A position above MAX_POS (1374 by default) makes the request fail at that entry, with no RAM access for it.
- R7: Entries 0 to errCount-1 are applied in index order, and entries at or above errCount are ignored. When an entry fails, the entries before it stay applied, and neither it nor any later entry touches the RAM.
- R8: errCount = 0 completes with fail = 0, corrCount = 0 and no RAM access. errCount above MAX_ERR (4) completes with fail = 1 and no RAM access.
- R9: Each repaired byte costs exactly one read cycle (ramEn=1, ramWe=0) and, in the very next cycle, one write cycle to the same address. The written data is the byte read (one-cycle read latency) XOR the mask.
- R10: done is a one-cycle pulse. At done, corrCount equals errCount on success and 0 on failure. fail and corrCount then hold their values until the next accepted start.
- R11: Let E be the number of entries examined (the failing entry included) and B the number of bytes repaired. Counting the edge that samples start as edge 1, done becomes visible after edge 1 + max(E,1) + 2B.
- R12: A start pulse while a request is in progress is ignored. The inputs are sampled only when start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| errCount | input | CNT_W | Number of valid entries |
| errPos | input | MAX_ERR*POS_W | Symbol positions, entry k in bits [k*POS_W +: POS_W] |
| errPat | input | MAX_ERR*12 | Error patterns, entry k in bits [k*12 +: 12] |
| ramEn | output | 1 | RAM access strobe |
| ramWe | output | 1 | RAM write enable (read when low) |
| ramAddr | output | ADDR_W | Byte address |
| ramWdata | output | 8 | Write data |
| ramRdata | input | 8 | Read data, valid the cycle after a read |
| done | output | 1 | Completion pulse |
| fail | output | 1 | Request was uncorrectable |
| corrCount | output | CNT_W | Symbols corrected, 0 on failure |

## Verification
The assertions assume that the RAM returns read data exactly one cycle after a read and does not change it before the write that follows. They also assume that errCount and the entry buses are steady only on the cycle start is accepted. The bench RAM model meets the first assumption by construction. To test the second, the bench deliberately changes the entry buses, and pulses start again, while a request is running. The position sweep keeps each request within a small page configuration in which every legal position lands inside the modelled memory, while positions past the limit probe the range check.

// File: rtl/rsfix_pkg.sv
package rsfix_pkg;

  // Width of one Reed-Solomon code symbol
  localparam int SYM_W = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } fix_state_t;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic load;     // capture request inputs
    logic advance;  // move to the next entry
    logic selHi;    // second byte of the current symbol
    logic rdStb;    // read cycle
    logic wrStb;    // write-back cycle
    logic finish;   // latch results
    logic finFail;  // result is a failure
  } rsfix_ctl_t;

endpackage

// File: rtl/rsfix_ctrl.sv
module rsfix_ctrl
  import rsfix_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       countBad,
  input  logic       countZero,
  input  logic       entryBad,
  input  logic       twoBytes,
  input  logic       lastEntry,
  output rsfix_ctl_t ctl,
  output logic       done
);

  fix_state_t state, nxtState;
  logic       hiReg, nxtHi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      hiReg <= 1'b0;
    end else begin
      state <= nxtState;
      hiReg <= nxtHi;
    end
  end

  always_comb begin
    ctl       = '0;
    ctl.selHi = hiReg;
    nxtState  = state;
    nxtHi     = hiReg;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.load = 1'b1;
          nxtState = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (countBad) begin
          ctl.finish  = 1'b1;
          ctl.finFail = 1'b1;
          nxtState    = ST_DONE;
        end else if (countZero) begin
          ctl.finish = 1'b1;
          nxtState   = ST_DONE;
        end else if (entryBad) begin
          ctl.finish  = 1'b1;
          ctl.finFail = 1'b1;
          nxtState    = ST_DONE;
        end else begin
          nxtHi    = 1'b0;
          nxtState = ST_READ;
        end
      end
      ST_READ: begin
        ctl.rdStb = 1'b1;
        nxtState  = ST_WRITE;
      end
      ST_WRITE: begin
        ctl.wrStb = 1'b1;
        if (twoBytes && !hiReg) begin
          nxtHi    = 1'b1;
          nxtState = ST_READ;
        end else if (lastEntry) begin
          ctl.finish = 1'b1;
          nxtState   = ST_DONE;
        end else begin
          ctl.advance = 1'b1;
          nxtState    = ST_CHECK;
        end
      end
      ST_DONE: nxtState = ST_IDLE;
      default: nxtState = ST_IDLE;
    endcase
  end

  assign done = (state == ST_DONE);

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: every write-back directly follows a read
  a_r9_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.wrStb |-> $past(ctl.rdStb));

  // R9: a read is always followed by its write-back
  a_r9_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.rdStb |=> ctl.wrStb);

endmodule

// File: rtl/rsfix_datapath.sv
module rsfix_datapath
  import rsfix_pkg::*;
#(
  parameter  int DATA_BYTES  = 2048,
  parameter  int SPARE_BYTES = 64,
  parameter  int MAX_ERR     = 4,
  parameter  int POS_W       = 11,
  parameter  int MAX_POS     = 1374,
  localparam int TOTAL_BYTES = DATA_BYTES + SPARE_BYTES,
  localparam int ADDR_W      = $clog2(TOTAL_BYTES),
  localparam int CNT_W       = $clog2(MAX_ERR + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  rsfix_ctl_t               ctl,
  input  logic [CNT_W-1:0]         errCount,
  input  logic [MAX_ERR*POS_W-1:0] errPos,
  input  logic [MAX_ERR*SYM_W-1:0] errPat,
  input  logic [7:0]               ramRdata,
  output logic [ADDR_W-1:0]        ramAddr,
  output logic [7:0]               ramWdata,
  output logic                     countBad,
  output logic                     countZero,
  output logic                     entryBad,
  output logic                     twoBytes,
  output logic                     lastEntry,
  output logic                     resFail,
  output logic [CNT_W-1:0]         resCount
);

  localparam int WIDE_W = (POS_W + 2 > ADDR_W) ? POS_W + 2 : ADDR_W;
  localparam logic [POS_W-1:0]  MAX_POS_V = POS_W'(MAX_POS);
  localparam logic [CNT_W-1:0]  MAX_ERR_V = CNT_W'(MAX_ERR);
  localparam logic [ADDR_W:0]   TOTAL_V   = (ADDR_W + 1)'(TOTAL_BYTES);

  logic [POS_W-1:0] posReg [MAX_ERR];
  logic [SYM_W-1:0] patReg [MAX_ERR];
  logic [CNT_W-1:0] cntReg;
  logic [CNT_W-1:0] idx;

  // Entry capture, one register pair per slot
  for (genvar g = 0; g < MAX_ERR; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        posReg[g] <= '0;
        patReg[g] <= '0;
      end else if (ctl.load) begin
        posReg[g] <= errPos[g*POS_W +: POS_W];
        patReg[g] <= errPat[g*SYM_W +: SYM_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntReg <= '0;
      idx    <= '0;
    end else if (ctl.load) begin
      cntReg <= errCount;
      idx    <= '0;
    end else if (ctl.advance) begin
      idx    <= idx + CNT_W'(1);
    end
  end

  // Current entry select
  logic [POS_W-1:0] curPos;
  logic [SYM_W-1:0] curPat;
  always_comb begin
    curPos = '0;
    curPat = '0;
    for (int k = 0; k < MAX_ERR; k++) begin
      if (idx == CNT_W'(k)) begin
        curPos = posReg[k];
        curPat = patReg[k];
      end
    end
  end

  // Symbol position to byte addresses and nibble masks
  logic [ADDR_W-1:0] halfA, loAddr, hiAddr;
  logic [7:0]        loMask, hiMask;
  always_comb begin
    halfA = ADDR_W'((WIDE_W'(curPos) * WIDE_W'(3)) >> 1);
    if (curPos == '0) begin
      loAddr = '0;
      loMask = curPat[7:0];
      hiAddr = '0;
      hiMask = '0;
    end else if (curPos[0]) begin
      loAddr = halfA;
      loMask = curPat[11:4];
      hiAddr = halfA + ADDR_W'(1);
      hiMask = {curPat[3:0], 4'h0};
    end else begin
      loAddr = halfA - ADDR_W'(1);
      loMask = {4'h0, curPat[11:8]};
      hiAddr = halfA;
      hiMask = curPat[7:0];
    end
  end

  assign ramAddr   = ctl.selHi ? hiAddr : loAddr;
  assign ramWdata  = ramRdata ^ (ctl.selHi ? hiMask : loMask);

  assign countBad  = (cntReg > MAX_ERR_V);
  assign countZero = (cntReg == '0);
  assign entryBad  = (curPos > MAX_POS_V) ||
                     ((curPos == '0) && (curPat[11:8] != 4'h0));
  assign twoBytes  = (curPos != '0);
  assign lastEntry = (idx == cntReg - CNT_W'(1));

  // Result registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resFail  <= 1'b0;
      resCount <= '0;
    end else if (ctl.load) begin
      resFail  <= 1'b0;
      resCount <= '0;
    end else if (ctl.finish) begin
      resFail  <= ctl.finFail;
      resCount <= ctl.finFail ? '0 : cntReg;
    end
  end

  // R6 / R8: no read is issued for a rejected entry or count
  a_r6_no_access_when_bad: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.rdStb |-> (!entryBad && !countBad && !countZero));

  // R5: every access lies inside the page
  a_r5_addr_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.rdStb || ctl.wrStb) |-> ({1'b0, ramAddr} < TOTAL_V));

  // R7: the entry index never passes the captured count
  a_r7_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.rdStb |-> (idx < cntReg));

endmodule

// File: rtl/rs_symbol_fixer.sv
module rs_symbol_fixer
  import rsfix_pkg::*;
#(
  parameter  int DATA_BYTES  = 2048,
  parameter  int SPARE_BYTES = 64,
  parameter  int MAX_ERR     = 4,
  parameter  int POS_W       = 11,
  parameter  int MAX_POS     = 1374,
  localparam int TOTAL_BYTES = DATA_BYTES + SPARE_BYTES,
  localparam int ADDR_W      = $clog2(TOTAL_BYTES),
  localparam int CNT_W       = $clog2(MAX_ERR + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [CNT_W-1:0]         errCount,
  input  logic [MAX_ERR*POS_W-1:0] errPos,
  input  logic [MAX_ERR*SYM_W-1:0] errPat,
  output logic                     ramEn,
  output logic                     ramWe,
  output logic [ADDR_W-1:0]        ramAddr,
  output logic [7:0]               ramWdata,
  input  logic [7:0]               ramRdata,
  output logic                     done,
  output logic                     fail,
  output logic [CNT_W-1:0]         corrCount
);

  rsfix_ctl_t ctl;
  logic countBad, countZero, entryBad, twoBytes, lastEntry;

  rsfix_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .countBad  (countBad),
    .countZero (countZero),
    .entryBad  (entryBad),
    .twoBytes  (twoBytes),
    .lastEntry (lastEntry),
    .ctl       (ctl),
    .done      (done)
  );

  rsfix_datapath #(
    .DATA_BYTES  (DATA_BYTES),
    .SPARE_BYTES (SPARE_BYTES),
    .MAX_ERR     (MAX_ERR),
    .POS_W       (POS_W),
    .MAX_POS     (MAX_POS)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .errCount  (errCount),
    .errPos    (errPos),
    .errPat    (errPat),
    .ramRdata  (ramRdata),
    .ramAddr   (ramAddr),
    .ramWdata  (ramWdata),
    .countBad  (countBad),
    .countZero (countZero),
    .entryBad  (entryBad),
    .twoBytes  (twoBytes),
    .lastEntry (lastEntry),
    .resFail   (fail),
    .resCount  (corrCount)
  );

  assign ramEn = ctl.rdStb | ctl.wrStb;
  assign ramWe = ctl.wrStb;

  // R9: write-back hits the address just read
  a_r9_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ramWe |-> ($past(ramEn && !ramWe) && (ramAddr == $past(ramAddr))));

  // R10: a failed request reports no corrections
  a_r10_fail_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> (corrCount == '0));

  // R10: reported count never exceeds the correction limit
  a_r10_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (corrCount <= CNT_W'(MAX_ERR)));

  // R1 / R10: no RAM activity while completion is signalled
  a_r1_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ramEn);

endmodule

// File: tb/rs_symbol_fixer_tb_top.sv
module rs_symbol_fixer_tb_top;

  localparam int DB   = 32;
  localparam int SB   = 8;
  localparam int ME   = 4;
  localparam int PW   = 11;
  localparam int MP   = 25;
  localparam int TOT  = DB + SB;
  localparam int AW   = $clog2(TOT);
  localparam int CW   = $clog2(ME + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [CW-1:0]   errCount = '0;
  logic [ME*PW-1:0] errPos = '0;
  logic [ME*12-1:0] errPat = '0;
  logic            ramEn, ramWe;
  logic [AW-1:0]   ramAddr;
  logic [7:0]      ramWdata;
  logic [7:0]      ramRdata = '0;
  logic            done, fail;
  logic [CW-1:0]   corrCount;

  always #2 clk = ~clk;

  rs_symbol_fixer #(
    .DATA_BYTES (DB), .SPARE_BYTES (SB), .MAX_ERR (ME), .POS_W (PW), .MAX_POS (MP)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .start (start), .errCount (errCount),
    .errPos (errPos), .errPat (errPat), .ramEn (ramEn), .ramWe (ramWe),
    .ramAddr (ramAddr), .ramWdata (ramWdata), .ramRdata (ramRdata),
    .done (done), .fail (fail), .corrCount (corrCount)
  );

  // Bench RAM with one-cycle read latency and protocol monitor
  logic [7:0] mem    [TOT];
  logic [7:0] expMem [TOT];
  int rdCnt, wrCnt, protoErr;
  logic lastRead = 1'b0;
  logic [AW-1:0] lastAddr = '0;

  always @(posedge clk) begin
    if (ramEn) begin
      if (int'(ramAddr) >= TOT) protoErr++;
      else if (ramWe) begin
        if (!lastRead || ramAddr != lastAddr) protoErr++;
        mem[ramAddr] <= ramWdata;
        wrCnt++;
      end else begin
        ramRdata <= mem[ramAddr];
        rdCnt++;
      end
      lastRead <= !ramWe;
      lastAddr <= ramAddr;
    end else begin
      lastRead <= 1'b0;
    end
  end

  int total = 0;
  int failed = 0;
  int seed = 0;
  int casePos [ME];
  int casePat [ME];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fillByte(input int i, input int s);
    return 8'((i * 37) + (s * 13) + 7);
  endfunction

  task automatic run_case(input int cnt, input bit poke, input string tag);
    bit expFail = 0;
    int B = 0, E = 0, expN, n, mism, firstBad, expCorr;
    logic savedFail;
    logic [CW-1:0] savedCorr;
    seed++;
    for (int i = 0; i < TOT; i++) begin
      mem[i]    = fillByte(i, seed);
      expMem[i] = fillByte(i, seed);
    end
    // expected result from the position arithmetic
    if (cnt > ME) expFail = 1;
    else begin
      for (int i = 0; i < cnt; i++) begin
        int p = casePos[i];
        int t = casePat[i];
        E = i + 1;
        if (p > MP) begin expFail = 1; break; end
        if (p == 0) begin
          if (t > 255) begin expFail = 1; break; end
          expMem[0] ^= 8'(t);
          B += 1;
        end else begin
          int a = (3 * p) / 2;
          if (p % 2 == 1) begin
            expMem[a]     ^= 8'(t >> 4);
            expMem[a + 1] ^= 8'((t & 15) << 4);
          end else begin
            expMem[a - 1] ^= 8'(t >> 8);
            expMem[a]     ^= 8'(t & 255);
          end
          B += 2;
        end
      end
    end
    expN    = 1 + ((E > 1) ? E : 1) + 2 * B;
    expCorr = expFail ? 0 : cnt;

    errCount = CW'(cnt);
    for (int k = 0; k < ME; k++) begin
      errPos[k*PW +: PW] = PW'(casePos[k]);
      errPat[k*12 +: 12] = 12'(casePat[k]);
    end
    rdCnt = 0; wrCnt = 0; protoErr = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    // R12: inputs change after acceptance and may be re-pulsed
    errPos = '1;
    errPat = '1;
    errCount = CW'(1);
    while (!done) begin
      if (n > 300) break;
      start = (poke && n == 2);
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n == expN, poke ? "R12" : "R11", "done latency", n, expN);
    chk(fail == expFail, tag, "fail flag", int'(fail), int'(expFail));
    chk(int'(corrCount) == expCorr, "R10", "corrCount", int'(corrCount), expCorr);
    chk(rdCnt == B, "R9", "read cycles", rdCnt, B);
    chk(wrCnt == B, "R9", "write cycles", wrCnt, B);
    chk(protoErr == 0, "R9", "protocol errors", protoErr, 0);
    mism = 0; firstBad = -1;
    for (int i = 0; i < TOT; i++)
      if (mem[i] !== expMem[i]) begin
        mism++;
        if (firstBad < 0) firstBad = i;
      end
    chk(mism == 0, tag, "page bytes wrong", mism, 0);
    if (mism != 0)
      $display("  first wrong byte %0d: actual=%0h expected=%0h", firstBad,
               mem[firstBad], expMem[firstBad]);
    savedFail = fail;
    savedCorr = corrCount;
    repeat (3) @(negedge clk);
    chk(!done, "R10", "done held high", int'(done), 0);
    chk(fail == savedFail && corrCount == savedCorr, "R10", "results held",
        int'(corrCount), int'(savedCorr));
  endtask

  task automatic set_entries(input int p0, t0, p1, t1, p2, t2, p3, t3);
    casePos[0] = p0; casePat[0] = t0;
    casePos[1] = p1; casePat[1] = t1;
    casePos[2] = p2; casePat[2] = t2;
    casePos[3] = p3; casePat[3] = t3;
  endtask

  initial begin
    int pats [3] = '{12'hFFF, 12'h0A5, 12'h6C3};
    repeat (4) @(negedge clk);
    // R1: reset state
    for (int c = 0; c < 4; c++) begin
      chk(!done && !fail && corrCount == '0, "R1", "outputs in reset",
          int'(done) + int'(fail) + int'(corrCount), 0);
      chk(!ramEn, "R1", "ramEn in reset", int'(ramEn), 0);
      @(negedge clk);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!done && !fail && !ramEn, "R1", "idle after reset",
        int'(done) + int'(fail) + int'(ramEn), 0);

    // Sweep of every position, single entry
    for (int p = 0; p <= MP + 2; p++) begin
      for (int j = 0; j < 3; j++) begin
        string tag;
        int a = (3 * p) / 2;
        if (p == 0) tag = "R4";
        else if (p > MP) tag = "R6";
        else if ((p % 2 == 1 && a == DB - 1) || (p % 2 == 0 && a == DB)) tag = "R5";
        else if (p % 2 == 1) tag = "R2";
        else tag = "R3";
        set_entries(p, pats[j], 3, 12'h111, 4, 12'h222, 5, 12'h333);
        run_case(1, 1'b0, tag);
      end
    end

    // Four entries in order, one of them straddling the boundary
    set_entries(3, 12'h9A1, 10, 12'h5F0, 21, 12'hABC, 25, 12'h00F);
    run_case(4, 1'b0, "R7");
    // Same symbol twice cancels out
    set_entries(7, 12'h3C5, 7, 12'h3C5, 0, 12'h0, 0, 12'h0);
    run_case(2, 1'b0, "R7");
    // Failure in the middle: earlier kept, later skipped
    set_entries(2, 12'h123, 9, 12'h456, 30, 12'h789, 4, 12'hFFF);
    run_case(4, 1'b0, "R7");
    set_entries(5, 12'h0F0, 0, 12'h1FF, 6, 12'hF0F, 8, 12'h111);
    run_case(3, 1'b0, "R4");
    // Large out-of-range value
    set_entries(2000, 12'h001, 1, 12'h001, 1, 12'h001, 1, 12'h001);
    run_case(1, 1'b0, "R6");
    // Entries beyond the count are ignored
    set_entries(11, 12'hA5A, 12, 12'h5A5, 13, 12'hFFF, 14, 12'hFFF);
    run_case(2, 1'b0, "R7");
    // Count corner cases
    set_entries(1, 12'hFFF, 2, 12'hFFF, 3, 12'hFFF, 4, 12'hFFF);
    run_case(0, 1'b0, "R8");
    run_case(5, 1'b0, "R8");
    run_case(7, 1'b0, "R8");
    run_case(4, 1'b0, "R8");
    // Start pulsed while busy
    set_entries(21, 12'h777, 22, 12'h888, 0, 12'h0AA, 24, 12'h999);
    run_case(4, 1'b1, "R12");
    set_entries(1, 12'h00F, 0, 12'h000, 0, 12'h000, 0, 12'h000);
    run_case(1, 1'b1, "R12");

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL R11 watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule